// File: doc/BRIEF.md
# Configurable Level/Edge Interrupt Controller

This block gathers 32 interrupt request lines into one controller that a processor reads and writes through a small word-addressed register port. Each line is configured separately to be sensed either as a level or as an edge, with a polarity bit that selects active-high or rising (1) versus active-low or falling (0). Every detected event is latched into a pending register. An enable register gates the pending bits into a masked view. A routing register sends each masked bit either to a normal or to a critical interrupt output.

A read-only vector register gives the number of the lowest-numbered source whose masked bit is set, together with a valid flag, so that a handler can find its source in one read. Larger trees are built outside the block by wiring one controller's output to a source input of another controller. In every register, source n sits at bit 31-n, so source 0 is the most significant bit. A level-sensed source cannot be cleared while its input is still active, whatever its enable bit says. Changing the sense mode or the polarity of a source discards that source's latched event.

Top module: `irqc_top`

## Requirements
- R1: Source n (input bit `irq_src[n]`) maps to bit 31-n of the pending, enable, routing, polarity, trigger and masked registers.
- R2: After reset the enable, routing, trigger and pending registers read zero, the polarity register reads all ones, both outputs are low and the vector register reads zero.
- R3: Writing to the pending register clears every bit written as 1 and leaves every bit written as 0 unchanged. An edge-latched bit stays set until it is cleared this way.
- R4: A source with trigger bit 0 (level) sets its pending bit whenever its synchronised input equals its polarity bit. A clear has no effect while the input stays active, whether or not the source is enabled. The bit stays latched after the input goes inactive, until it is cleared.
- R5: A source with trigger bit 1 (edge) sets its pending bit on a rising transition (polarity 1) or a falling transition (polarity 0) of its input after two synchronising flops. The bit is visible on a read after the third rising clock edge that follows the input change, and the opposite transition sets nothing.
- R6: The masked register reads as pending AND enable. Writes to the masked register and to the vector register change no state.
- R7: `irq_norm` is the registered OR of the masked bits whose routing bit is 0. `irq_crit` is the registered OR of the masked bits whose routing bit is 1. Both follow the registers one clock later.
- R8: The vector register holds, in bits [4:0], the number of the lowest-numbered source with its masked bit set, and holds the valid flag in bit 31. It reads exactly zero when the masked register is zero.
- R9: A write to the trigger or polarity register clears the pending bit of every source whose bit in that register changes.
- R10: Word addresses are 0 pending, 1 enable, 2 routing, 3 polarity, 4 trigger, 5 masked, 6 vector. Address 7 reads zero, and reads return the current contents in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 32 | Interrupt request lines, bit n is source n |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
Random steady levels are applied under random polarity, enable and routing settings. These runs show whether level sensing honours polarity and whether the masked, vector and two output views agree with the pending bits. Random pairs of input words under edge sensing separate rising, falling and unchanged lines, and they expose any polarity inversion or wrong bit reversal. Directed cases cover the exact three-edge latency, a clear against an active level with the enable both on and off, the discarding of a latched event by a mode change, priority between two sources, and writes to the read-only addresses.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [2:0] {
        A_STAT = 3'd0,
        A_ENAB = 3'd1,
        A_CRIT = 3'd2,
        A_POL  = 3'd3,
        A_TRIG = 3'd4,
        A_MASK = 3'd5,
        A_VEC  = 3'd6,
        A_NONE = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] sync,
    output logic [W-1:0] sync_d
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign sync   = sync_q;
    assign sync_d = hist_q;

endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] sync,
    input  logic [NSRC-1:0] sync_d,
    input  logic [NSRC-1:0] trig,
    input  logic [NSRC-1:0] pol,
    input  logic [NSRC-1:0] clr_req,
    input  logic [NSRC-1:0] cfg_chg,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] lvl_set
);

    logic [NSRC-1:0] pend_q;

    for (genvar b = 0; b < NSRC; b++) begin : g_bit
        logic act;
        logic edge_hit;
        logic set_now;

        assign act      = sync[b] ~^ pol[b];
        assign edge_hit = pol[b] ? (sync[b] & ~sync_d[b]) : (~sync[b] & sync_d[b]);
        assign set_now  = trig[b] ? edge_hit : act;
        assign lvl_set[b] = ~trig[b] & act;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[b] <= 1'b0;
            end else if (cfg_chg[b]) begin
                pend_q[b] <= 1'b0;
            end else begin
                pend_q[b] <= (pend_q[b] & ~clr_req[b]) | set_now;
            end
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  masked,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);

    always_comb begin
        idx = '0;
        for (int b = 0; b < NSRC; b++) begin
            if (masked[b]) begin
                idx = IDX_W'(NSRC - 1 - b);
            end
        end
    end

    assign valid = |masked;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_src,
    input  logic [2:0]      bus_addr,
    input  logic            bus_we,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic            irq_norm,
    output logic            irq_crit
);

    localparam int IDX_W = $clog2(NSRC);
    localparam int PAD_W = NSRC - 1 - IDX_W;

    logic [NSRC-1:0] raw_r;
    logic [NSRC-1:0] sync_r;
    logic [NSRC-1:0] sync_d_r;
    logic [NSRC-1:0] enab_q;
    logic [NSRC-1:0] crit_q;
    logic [NSRC-1:0] pol_q;
    logic [NSRC-1:0] trig_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] lvl_set;
    logic [NSRC-1:0] masked;
    logic [NSRC-1:0] clr_req;
    logic [NSRC-1:0] cfg_chg;
    logic [IDX_W-1:0] vec_idx;
    logic            vec_valid;
    logic            wr_trig;
    logic            wr_pol;
    reg_addr_e       addr_e;

    // source n lands on register bit NSRC-1-n
    for (genvar n = 0; n < NSRC; n++) begin : g_rev
        assign raw_r[NSRC-1-n] = irq_src[n];
    end

    irqc_sync #(.W(NSRC)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_r),
        .sync   (sync_r),
        .sync_d (sync_d_r)
    );

    assign addr_e  = reg_addr_e'(bus_addr);
    assign wr_trig = bus_we && (addr_e == A_TRIG);
    assign wr_pol  = bus_we && (addr_e == A_POL);
    assign clr_req = (bus_we && (addr_e == A_STAT)) ? bus_wdata : '0;
    assign cfg_chg = (wr_trig ? (bus_wdata ^ trig_q) : '0)
                   | (wr_pol  ? (bus_wdata ^ pol_q)  : '0);

    irqc_detect #(.NSRC(NSRC)) det_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync    (sync_r),
        .sync_d  (sync_d_r),
        .trig    (trig_q),
        .pol     (pol_q),
        .clr_req (clr_req),
        .cfg_chg (cfg_chg),
        .pend    (pend_q),
        .lvl_set (lvl_set)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enab_q <= '0;
            crit_q <= '0;
            pol_q  <= '1;
            trig_q <= '0;
        end else if (bus_we) begin
            unique case (addr_e)
                A_ENAB:  enab_q <= bus_wdata;
                A_CRIT:  crit_q <= bus_wdata;
                A_POL:   pol_q  <= bus_wdata;
                A_TRIG:  trig_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign masked = pend_q & enab_q;

    irqc_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) prio_i (
        .masked (masked),
        .idx    (vec_idx),
        .valid  (vec_valid)
    );

    // registered request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_norm <= 1'b0;
            irq_crit <= 1'b0;
        end else begin
            irq_norm <= |(masked & ~crit_q);
            irq_crit <= |(masked & crit_q);
        end
    end

    // read port
    always_comb begin
        unique case (addr_e)
            A_STAT:  bus_rdata = pend_q;
            A_ENAB:  bus_rdata = enab_q;
            A_CRIT:  bus_rdata = crit_q;
            A_POL:   bus_rdata = pol_q;
            A_TRIG:  bus_rdata = trig_q;
            A_MASK:  bus_rdata = masked;
            A_VEC:   bus_rdata = vec_valid ? {1'b1, {PAD_W{1'b0}}, vec_idx} : '0;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_we,
    input logic [2:0]      bus_addr,
    input logic [NSRC-1:0] bus_wdata,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] enab,
    input logic [NSRC-1:0] crit,
    input logic [NSRC-1:0] trig,
    input logic [NSRC-1:0] lvl_set,
    input logic            vec_valid,
    input logic            irq_norm,
    input logic            irq_crit
);

    logic cfg_wr;
    logic stat_wr;
    assign cfg_wr  = bus_we && ((bus_addr == A_TRIG) || (bus_addr == A_POL));
    assign stat_wr = bus_we && (bus_addr == A_STAT);

    // R3: pending bits never drop without a clear or a config write
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr || stat_wr) |=> ((pend & $past(pend)) == $past(pend)));

    // R4: an active level source is pending next cycle despite any clear
    p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ((pend & $past(lvl_set)) == $past(lvl_set)));

    // R7: normal output follows unrouted masked bits
    p_norm_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & enab & ~crit)) |=> irq_norm);

    p_norm_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend & enab & ~crit)) |=> !irq_norm);

    // R7: critical output follows routed masked bits
    p_crit_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & enab & crit)) |=> irq_crit);

    // R8: valid flag matches a non-empty masked set
    p_vec_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid == (|(pend & enab)));

    // R9: a trigger write clears every source whose mode changes
    p_cfg_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == A_TRIG)) |=>
            ((pend & ($past(bus_wdata) ^ $past(trig))) == '0));

endmodule

bind irqc_top irqc_checker #(.NSRC(NSRC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend      (pend_q),
    .enab      (enab_q),
    .crit      (crit_q),
    .trig      (trig_q),
    .lvl_set   (lvl_set),
    .vec_valid (vec_valid),
    .irq_norm  (irq_norm),
    .irq_crit  (irq_crit)
);

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm;
    logic        irq_crit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irqc_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_norm  (irq_norm),
        .irq_crit  (irq_crit)
    );

    function automatic logic [31:0] rev(input logic [31:0] s);
        logic [31:0] r;
        for (int n = 0; n < 32; n++) r[31-n] = s[n];
        return r;
    endfunction

    function automatic logic [31:0] exp_vec(input logic [31:0] m);
        for (int n = 0; n < 32; n++) begin
            if (m[31-n]) return 32'h8000_0000 | 32'(n);
        end
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(1, v); chk("R2 enable", v, 32'h0);
        rd(2, v); chk("R2 routing", v, 32'h0);
        rd(4, v); chk("R2 trigger", v, 32'h0);
        rd(3, v); chk("R2 polarity", v, 32'hFFFF_FFFF);
        rd(0, v); chk("R2 pending", v, 32'h0);
        rd(6, v); chk("R2 vector", v, 32'h0);
        chk("R2 outputs", {30'h0, irq_norm, irq_crit}, 32'h0);

        // R1 R4 level source 0 at the MSB
        wr(1, 32'hFFFF_FFFF);
        irq_src = 32'h1;
        settle();
        rd(0, v); chk("R1 source0 msb", v, 32'h8000_0000);
        rd(6, v); chk("R8 vector src0", v, 32'h8000_0000);
        chk("R7 norm high", {31'h0, irq_norm}, 32'h1);

        // R4 clear while active, enabled then disabled
        wr(0, 32'hFFFF_FFFF);
        rd(0, v); chk("R4 clear active enabled", v, 32'h8000_0000);
        wr(1, 32'h0);
        wr(0, 32'hFFFF_FFFF);
        rd(0, v); chk("R4 clear active disabled", v, 32'h8000_0000);
        irq_src = 32'h0;
        settle();
        rd(0, v); chk("R4 latched after inactive", v, 32'h8000_0000);
        wr(0, 32'h0);
        rd(0, v); chk("R3 write zero keeps", v, 32'h8000_0000);
        wr(0, 32'h8000_0000);
        rd(0, v); chk("R3 clear inactive", v, 32'h0);

        // R8 priority between sources 3 and 7, R7 routing
        wr(1, 32'hFFFF_FFFF);
        irq_src = (32'h1 << 3) | (32'h1 << 7);
        settle();
        rd(6, v); chk("R8 lowest wins", v, 32'h8000_0003);
        wr(2, 32'h1 << 28);
        irq_src = 32'h1 << 3;
        settle();
        wr(0, 32'hFFFF_FFFF);
        settle();
        chk("R7 crit routed", {30'h0, irq_norm, irq_crit}, 32'h1);

        // R6 masked view and ignored writes
        wr(1, 32'h1 << 28);
        wr(5, 32'hFFFF_FFFF);
        wr(6, 32'hFFFF_FFFF);
        rd(1, v); chk("R6 enable untouched", v, 32'h1 << 28);
        rd(0, v); chk("R6 pending untouched", v, 32'h1 << 28);
        rd(5, v); chk("R6 masked", v, 32'h1 << 28);
        rd(7, v); chk("R10 addr7 zero", v, 32'h0);

        // R9 mode change discards the latched bit
        wr(4, 32'h1 << 28);
        rd(0, v); chk("R9 trig change clears", v, 32'h0);
        settle();
        rd(0, v); chk("R9 steady edge stays clear", v, 32'h0);
        irq_src = 32'h0;
        wr(2, 32'h0);
        wr(4, 32'h0);
        settle();
        wr(0, 32'hFFFF_FFFF);

        // R5 rising edge latency on source 5 (bit 26)
        wr(4, 32'h1 << 26);
        wr(0, 32'hFFFF_FFFF);
        @(negedge clk);
        irq_src = 32'h1 << 5;
        @(negedge clk);
        @(negedge clk);
        rd(0, v); chk("R5 not yet after two edges", v, 32'h0);
        @(negedge clk);
        rd(0, v); chk("R5 set after third edge", v, 32'h1 << 26);
        irq_src = 32'h0;
        settle();
        rd(0, v); chk("R3 edge sticky", v, 32'h1 << 26);
        wr(0, 32'h1 << 26);
        settle();
        rd(0, v); chk("R5 falling ignored rising", v, 32'h0);
        wr(3, ~(32'h1 << 26));
        irq_src = 32'h1 << 5;
        settle();
        rd(0, v); chk("R5 rising ignored falling", v, 32'h0);
        irq_src = 32'h0;
        settle();
        rd(0, v); chk("R5 falling edge", v, 32'h1 << 26);

        // random level patterns
        for (int it = 0; it < 20; it++) begin
            logic [31:0] s, p, e, c, pe, m;
            s = $urandom; p = $urandom; e = $urandom; c = $urandom;
            wr(4, 32'h0); wr(3, p); wr(1, e); wr(2, c);
            irq_src = s;
            settle();
            wr(0, 32'hFFFF_FFFF);
            settle();
            pe = ~(rev(s) ^ p);
            m = pe & e;
            rd(0, v); chk("R4 random level pending", v, pe);
            rd(5, v); chk("R6 random masked", v, m);
            rd(6, v); chk("R8 random vector", v, exp_vec(m));
            chk("R7 random outputs", {30'h0, irq_norm, irq_crit},
                {30'h0, |(m & ~c), |(m & c)});
        end

        // random edge patterns
        for (int it = 0; it < 20; it++) begin
            logic [31:0] a, b, p, e, c, pe, m;
            a = $urandom; b = $urandom; p = $urandom; e = $urandom; c = $urandom;
            wr(4, 32'hFFFF_FFFF); wr(3, p); wr(1, e); wr(2, c);
            irq_src = a;
            settle();
            wr(0, 32'hFFFF_FFFF);
            irq_src = b;
            settle();
            pe = (p & ~rev(a) & rev(b)) | (~p & rev(a) & ~rev(b));
            m = pe & e;
            rd(0, v); chk("R5 random edge pending", v, pe);
            rd(6, v); chk("R8 random edge vector", v, exp_vec(m));
            chk("R7 random edge outputs", {30'h0, irq_norm, irq_crit},
                {30'h0, |(m & ~c), |(m & c)});
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule